// File: doc/BRIEF.md
# DMA Byte Mover

This block carries one byte of a DMA transfer between the wide A-side memory space (24-bit addresses) and the narrow B-side register window. A channel sequencer sets the direction, the transfer mode, the byte position inside the current transfer unit, the channel's destination register and the A-side address. It then pulses `start`. The block builds the B-side address from a fixed register page, the destination register and an offset chosen by the mode and byte position. It runs one read phase and one write phase on an external bus port, signals completion with a one-cycle `done`, and reports how many master clocks the byte took.

One combination is handled differently: the B-side address lands on the work-RAM data port while the A-side address itself lies in work RAM. When the copy goes from B to A, the read is replaced by an idle phase and the constant 0xFF is written to the A side. When it goes from A to B, both accesses are replaced by idle phases and nothing reaches the bus. The sequencer also reads the number of bytes per unit for the selected mode from `unitLen`.

Top module: `dmab_top`

## Requirements
- R1: After reset `done`, `busRd` and `busWr` are low and `cost` is 0.
- R2: With `dirBtoA`=1 and no port loop, the block reads the B-side address (`busToB`=1) and then writes the returned byte to the latched A-side address (`busToB`=0).
- R3: With `dirBtoA`=0 and no port loop, the block reads the A-side address and then writes the returned byte to the B-side address.
- R4: Every phase lasts 4 clocks. The read and write strobes are single-cycle and come in the last cycle of their phase, 4 and 8 cycles after the `start` edge. `cost` reads 8 while `done` is high.
- R5: The B-side address is 0x2100 OR the 8-bit sum (`destReg` + offset) with wrap-around, and it is driven on `busAddr[15:0]` with `busAddr[23:16]`=0.
- R6: The offset for `mode`/`byteIdx` is: modes 0, 2 and 6 give 0; modes 1 and 5 give `byteIdx[0]`; modes 3 and 7 give `byteIdx[1]`; mode 4 gives `byteIdx`. `unitLen` is 1 for mode 0, 2 for modes 1, 2 and 6, and 4 for modes 3, 4, 5 and 7.
- R7: An A-side address is in work RAM when its bank is 0x7E or 0x7F, or when bank bit 6 is clear and the offset is below 0x2000.
- R8: A port loop is a B-side address of 0x2180 together with a work-RAM A-side address. With `dirBtoA`=1 a port loop performs no read, idles for 4 clocks and then writes 0xFF to the A-side address, with `cost` 8.
- R9: A port loop with `dirBtoA`=0 issues neither a read nor a write, and `cost` is still 8.
- R10: `done` is high for exactly one cycle, the cycle after the last cycle of the final phase (9 cycles after the `start` edge).
- R11: A `start` pulse while a byte is in flight is ignored, and the running byte keeps its latched addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one byte; sampled only when idle |
| dirBtoA | input | 1 | 1: copy B side to A side, 0: A side to B side |
| mode | input | 3 | Transfer mode |
| byteIdx | input | 2 | Byte position within the transfer unit |
| destReg | input | 8 | Channel destination register (B-side low byte base) |
| aAddr | input | 24 | A-side address |
| busRdata | input | 8 | Read data returned by the bus port in the strobe cycle |
| busAddr | output | 24 | Address of the current phase |
| busToB | output | 1 | Current phase targets the B side |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busWdata | output | 8 | Write data |
| done | output | 1 | Byte complete pulse |
| cost | output | 5 | Master clocks used by the last byte |
| unitLen | output | 3 | Bytes per transfer unit for `mode` |

## Verification
A wrong phase or timer state inside the block shows at the ports as a strobe that moves away from cycle 4 or 8 after `start`, or as a `done` pulse that is not at cycle 9. Either is visible within a single byte. A wrong latched address, direction or loop decision shows in the strobe cycle as the wrong `busAddr`, a wrong `busToB`, or a missing or extra strobe. A wrong data latch shows at the write strobe as a `busWdata` that is neither the returned byte nor 0xFF. The bench records every strobe and its cycle for each byte, so each of these faults is caught on the byte where it occurs.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  localparam logic [15:0] B_PAGE     = 16'h2100;
  localparam logic [7:0]  PORT_LOW   = 8'h80;
  localparam logic [7:0]  FILL_BYTE  = 8'hFF;
  localparam logic [7:0]  WRAM_BANK0 = 8'h7E;
  localparam logic [7:0]  WRAM_BANK1 = 8'h7F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_SKIPRD,
    ST_SKIPWR
  } phase_e;

  typedef struct packed {
    logic capture;
    logic rdStrobe;
    logic wrStrobe;
    logic writePhase;
    logic busy;
    logic finish;
  } ctl_s;

  function automatic logic [1:0] modeOffset(input logic [2:0] m, input logic [1:0] idx);
    logic [1:0] r;
    case (m)
      3'd1, 3'd5: r = {1'b0, idx[0]};
      3'd3, 3'd7: r = {1'b0, idx[1]};
      3'd4:       r = idx;
      default:    r = 2'd0;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] modeLen(input logic [2:0] m);
    logic [2:0] r;
    case (m)
      3'd0:             r = 3'd1;
      3'd1, 3'd2, 3'd6: r = 3'd2;
      default:          r = 3'd4;
    endcase
    return r;
  endfunction

  function automatic logic inWorkRam(input logic [23:0] a);
    logic [7:0] bank;
    bank = a[23:16];
    return (bank == WRAM_BANK0) || (bank == WRAM_BANK1) ||
           (!bank[6] && (a[15:13] == 3'b000));
  endfunction

endpackage

// File: rtl/dmab_ctrl.sv
module dmab_ctrl
  import dmab_pkg::*;
#(
  parameter int ACC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic dirBtoA,
  input  logic loopHit,
  output ctl_s ctl,
  output logic done
);

  localparam int TMR_W = (ACC > 2) ? $clog2(ACC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ACC - 1);

  phase_e state, stateNxt;
  logic [TMR_W-1:0] tmr;
  logic loopDirQ;
  logic doneQ;
  logic phaseEnd;

  assign phaseEnd = (tmr == TMR_LAST);

  always_comb begin
    stateNxt = state;
    ctl = '0;
    ctl.busy = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.capture = 1'b1;
          stateNxt = loopHit ? ST_SKIPRD : ST_RD;
        end
      end
      ST_RD: begin
        ctl.rdStrobe = phaseEnd;
        if (phaseEnd) stateNxt = ST_WR;
      end
      ST_WR: begin
        ctl.writePhase = 1'b1;
        ctl.wrStrobe = phaseEnd;
        ctl.finish = phaseEnd;
        if (phaseEnd) stateNxt = ST_IDLE;
      end
      ST_SKIPRD: begin
        if (phaseEnd) stateNxt = loopDirQ ? ST_WR : ST_SKIPWR;
      end
      ST_SKIPWR: begin
        ctl.writePhase = 1'b1;
        ctl.finish = phaseEnd;
        if (phaseEnd) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      loopDirQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      state <= stateNxt;
      doneQ <= ctl.finish;
      if (ctl.capture) begin
        loopDirQ <= dirBtoA;
        tmr      <= '0;
      end else if (ctl.busy) begin
        tmr <= phaseEnd ? '0 : tmr + 1'b1;
      end
    end
  end

  assign done = doneQ;

endmodule

// File: rtl/dmab_datapath.sv
module dmab_datapath
  import dmab_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int COST_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic              dirBtoA,
  input  logic [2:0]        mode,
  input  logic [1:0]        byteIdx,
  input  logic [7:0]        destReg,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] busRdata,
  output logic              loopHit,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busToB,
  output logic [DATA_W-1:0] busWdata,
  output logic [COST_W-1:0] cost
);

  logic [7:0]        bLowIn;
  logic              dirQ;
  logic [ADDR_W-1:0] aQ;
  logic [7:0]        bLowQ;
  logic [DATA_W-1:0] dataQ;
  logic [COST_W-1:0] cntQ;
  logic [COST_W-1:0] costQ;
  logic              aSide;
  logic [ADDR_W-1:0] bFull;

  assign bLowIn  = destReg + {6'd0, modeOffset(mode, byteIdx)};
  assign loopHit = (bLowIn == PORT_LOW) && inWorkRam(aAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ  <= 1'b0;
      aQ    <= '0;
      bLowQ <= '0;
      dataQ <= '0;
      cntQ  <= '0;
      costQ <= '0;
    end else begin
      if (ctl.capture) begin
        dirQ  <= dirBtoA;
        aQ    <= aAddr;
        bLowQ <= bLowIn;
        cntQ  <= '0;
        if (loopHit) dataQ <= DATA_W'(FILL_BYTE);
      end else if (ctl.busy) begin
        cntQ <= cntQ + 1'b1;
      end
      if (ctl.rdStrobe) dataQ <= busRdata;
      if (ctl.finish)   costQ <= cntQ + 1'b1;
    end
  end

  assign aSide    = ctl.writePhase ? dirQ : !dirQ;
  assign bFull    = ADDR_W'(B_PAGE | {8'h00, bLowQ});
  assign busAddr  = aSide ? aQ : bFull;
  assign busToB   = ctl.busy && !aSide;
  assign busWdata = dataQ;
  assign cost     = costQ;

endmodule

// File: rtl/dmab_top.sv
module dmab_top
  import dmab_pkg::*;
#(
  parameter int ACC    = 4,
  parameter int COST_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dirBtoA,
  input  logic [2:0]        mode,
  input  logic [1:0]        byteIdx,
  input  logic [7:0]        destReg,
  input  logic [23:0]       aAddr,
  input  logic [7:0]        busRdata,
  output logic [23:0]       busAddr,
  output logic              busToB,
  output logic              busRd,
  output logic              busWr,
  output logic [7:0]        busWdata,
  output logic              done,
  output logic [COST_W-1:0] cost,
  output logic [2:0]        unitLen
);

  ctl_s ctl;
  logic loopHit;

  dmab_ctrl #(.ACC(ACC)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .dirBtoA (dirBtoA),
    .loopHit (loopHit),
    .ctl     (ctl),
    .done    (done)
  );

  dmab_datapath #(.ADDR_W(24), .DATA_W(8), .COST_W(COST_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .dirBtoA  (dirBtoA),
    .mode     (mode),
    .byteIdx  (byteIdx),
    .destReg  (destReg),
    .aAddr    (aAddr),
    .busRdata (busRdata),
    .loopHit  (loopHit),
    .busAddr  (busAddr),
    .busToB   (busToB),
    .busWdata (busWdata),
    .cost     (cost)
  );

  assign busRd   = ctl.rdStrobe;
  assign busWr   = ctl.wrStrobe;
  assign unitLen = modeLen(mode);

endmodule

// File: rtl/dmab_chk.sv
module dmab_chk #(
  parameter int ACC    = 4,
  parameter int COST_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [23:0]       busAddr,
  input logic              busToB,
  input logic              busRd,
  input logic              busWr,
  input logic              done,
  input logic [COST_W-1:0] cost
);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  a_r4_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> !busRd);

  a_r4_cost_eight: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cost == COST_W'(2 * ACC)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_write_last: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> done);

  a_r5_b_page: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) && busToB |-> (busAddr[23:8] == 16'h0021));

endmodule

bind dmab_top dmab_chk #(.ACC(ACC), .COST_W(COST_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busToB  (busToB),
  .busRd   (busRd),
  .busWr   (busWr),
  .done    (done),
  .cost    (cost)
);

// File: tb/tb_dmab_top.sv
module tb_dmab_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dirBtoA = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  byteIdx = '0;
  logic [7:0]  destReg = '0;
  logic [23:0] aAddr = '0;
  logic [7:0]  busRdata = '0;
  logic [23:0] busAddr;
  logic        busToB, busRd, busWr, done;
  logic [7:0]  busWdata;
  logic [4:0]  cost;
  logic [2:0]  unitLen;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  dmab_top dut (
    .clk(clk), .rstN(rstN), .start(start), .dirBtoA(dirBtoA), .mode(mode),
    .byteIdx(byteIdx), .destReg(destReg), .aAddr(aAddr), .busRdata(busRdata),
    .busAddr(busAddr), .busToB(busToB), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .done(done), .cost(cost), .unitLen(unitLen)
  );

  typedef struct packed {
    logic        dir;
    logic [2:0]  md;
    logic [1:0]  idx;
    logic [7:0]  dst;
    logic [23:0] a;
    logic [7:0]  rd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 2'd0, 8'h18, 24'h7E1234, 8'h5A},
    '{1'b1, 3'd1, 2'd1, 8'h22, 24'h001000, 8'hC3},
    '{1'b1, 3'd0, 2'd0, 8'h80, 24'h7F0010, 8'h11},
    '{1'b0, 3'd0, 2'd0, 8'h80, 24'h000100, 8'h22},
    '{1'b0, 3'd4, 2'd2, 8'h7E, 24'h802000, 8'h96},
    '{1'b1, 3'd3, 2'd3, 8'h7F, 24'h3F1FFF, 8'h33},
    '{1'b1, 3'd5, 2'd3, 8'hFF, 24'h400000, 8'hA7},
    '{1'b0, 3'd7, 2'd2, 8'h10, 24'hC00000, 8'h0F},
    '{1'b0, 3'd2, 2'd1, 8'h80, 24'h401000, 8'h44},
    '{1'b1, 3'd6, 2'd1, 8'h80, 24'hBF0000, 8'h55},
    '{1'b0, 3'd1, 2'd1, 8'h7F, 24'h7EFFFF, 8'h66}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] expOff(input logic [2:0] m, input logic [1:0] i);
    case (m)
      3'd0: return 2'd0;
      3'd1: return i & 2'd1;
      3'd2: return 2'd0;
      3'd3: return i >> 1;
      3'd4: return i;
      3'd5: return i & 2'd1;
      3'd6: return 2'd0;
      default: return i >> 1;
    endcase
  endfunction

  function automatic bit expWram(input logic [23:0] a);
    if (a[23:16] == 8'h7E || a[23:16] == 8'h7F) return 1'b1;
    if ((a[23:16] <= 8'h3F || (a[23:16] >= 8'h80 && a[23:16] <= 8'hBF)) && a[15:0] < 16'h2000)
      return 1'b1;
    return 1'b0;
  endfunction

  task automatic runOne(input vec_t v, input bit midStart, input string tag);
    int rdCnt = 0, wrCnt = 0, rdAt = 0, wrAt = 0, doneCnt = 0, doneAt = 0;
    logic [23:0] rdAddr = '0, wrAddr = '0;
    logic rdToB = 1'b0, wrToB = 1'b0;
    logic [7:0] wrData = '0;
    logic [4:0] costAt = '0;
    logic [7:0] bLow;
    logic [23:0] bAddr;
    bit loop;
    bLow  = v.dst + {6'd0, expOff(v.md, v.idx)};
    bAddr = {8'h00, 8'h21, bLow};
    loop  = (bLow == 8'h80) && expWram(v.a);
    @(negedge clk);
    dirBtoA = v.dir; mode = v.md; byteIdx = v.idx; destReg = v.dst;
    aAddr = v.a; busRdata = v.rd; start = 1'b1;
    for (int s = 1; s <= 12; s++) begin
      @(negedge clk);
      start = 1'b0;
      if (midStart && s == 2) begin
        start = 1'b1; destReg = v.dst ^ 8'h5C; aAddr = v.a ^ 24'h010101;
      end
      if (busRd) begin rdCnt++; rdAt = s; rdAddr = busAddr; rdToB = busToB; end
      if (busWr) begin wrCnt++; wrAt = s; wrAddr = busAddr; wrToB = busToB; wrData = busWdata; end
      if (done)  begin doneCnt++; doneAt = s; costAt = cost; end
    end
    start = 1'b0;
    if (loop && !v.dir) begin
      check(rdCnt == 0 && wrCnt == 0, {tag, " R9 no access"}, rdCnt * 16 + wrCnt, 0);
    end else if (loop) begin
      check(rdCnt == 0, {tag, " R8 no read"}, rdCnt, 0);
      check(wrCnt == 1 && wrAt == 8, {tag, " R8 R4 write slot"}, wrAt, 8);
      check(wrAddr == v.a && !wrToB, {tag, " R8 R7 write addr"}, wrAddr, v.a);
      check(wrData == 8'hFF, {tag, " R8 fill"}, wrData, 8'hFF);
    end else begin
      check(rdCnt == 1 && rdAt == 4, {tag, " R4 read slot"}, rdAt, 4);
      check(wrCnt == 1 && wrAt == 8, {tag, " R4 write slot"}, wrAt, 8);
      if (v.dir) begin
        check(rdAddr == bAddr && rdToB, {tag, " R2 R5 R6 read B"}, rdAddr, bAddr);
        check(wrAddr == v.a && !wrToB, {tag, " R2 write A"}, wrAddr, v.a);
      end else begin
        check(rdAddr == v.a && !rdToB, {tag, " R3 read A"}, rdAddr, v.a);
        check(wrAddr == bAddr && wrToB, {tag, " R3 R5 R6 write B"}, wrAddr, bAddr);
      end
      check(wrData == v.rd, {tag, " R2 R3 data"}, wrData, v.rd);
    end
    check(doneCnt == 1 && doneAt == 9, {tag, " R10 done"}, doneAt, 9);
    check(costAt == 5'd8, {tag, " R4 R8 R9 cost"}, costAt, 8);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired R10 actual=hang expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !busRd && !busWr && cost == 0, "R1 reset", {done, busRd, busWr, cost}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !busRd && !busWr, "R1 after release", {done, busRd, busWr}, 0);

    for (int i = 0; i < NV; i++) runOne(VECS[i], 1'b0, $sformatf("vec%0d", i));

    // R11: second start mid-byte has no effect on the running byte
    runOne(VECS[1], 1'b1, "R11 busy-start B2A");
    runOne(VECS[0], 1'b1, "R11 busy-start A2B");

    // R6: unit length per mode
    for (int m = 0; m < 8; m++) begin
      logic [2:0] el;
      el = (m == 0) ? 3'd1 : (m == 1 || m == 2 || m == 6) ? 3'd2 : 3'd4;
      mode = 3'(m);
      #1;
      check(unitLen == el, $sformatf("R6 unitLen mode%0d", m), unitLen, el);
    end

    // R7: bank 0x40 offset 0 is not work RAM, so a port target is copied
    runOne('{1'b0, 3'd0, 2'd0, 8'h80, 24'h400000, 8'h9C}, 1'b0, "R7 bank40");
    // R7: offset 0x1FFF in bank 0x00 is work RAM
    runOne('{1'b0, 3'd0, 2'd0, 8'h80, 24'h001FFF, 8'h9D}, 1'b0, "R7 edge1FFF");

    @(negedge clk);
    check(!done, "R10 idle after", done, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule